// File: doc/BRIEF.md
# Two-Level Interrupt Destination Router

This block steers every interrupt source to exactly one destination chosen by a per-source 3-bit selector register. The source index space is split. Indices below `N_LOW` belong to the first-level router. Each of those sources picks the main processor, auxiliary processor A or auxiliary processor B.

Indices from `N_LOW` upward belong to the second-level router, which has seven choices per source:
- five shared lines, each of which ORs the sources of one group of `GRP_W` sources;
- a direct request to the boot microcontroller;
- a hand-off back into the first level.

Shared lines A, D and E are meant for the main processor, line B for auxiliary processor A and line C for auxiliary processor B. Handed-off sources of one group are merged into a single request. That request then takes a first-level selector of its own, so the main processor can move it at run time without touching the second-level choice.

All selectors sit in one flat register space, written through a single-cycle write strobe. The outputs are combinational in the interrupt inputs and the registered selectors. There is no streaming data path, so every pin is a plain level signal and no valid/ready handshake exists.

Top module: `irq_dest_router`

## Requirements
- R1: After reset every selector is 0, so each first-level source drives its main-processor bit and each second-level source drives shared line A of its group.
- R2: A source with index below `N_LOW` can only affect bit `i` of `main_req`, `auxa_req` and `auxb_req`. It never affects the shared lines, `boot_req` or the hand-off bits `N_LOW` and above.
- R3: First-level selector codes: 0 selects `main_req`, 1 selects `auxa_req`, 2 selects `auxb_req`, and codes 3 to 7 route the source nowhere.
- R4: Second-level selector codes: 0 selects line A, 2 line D, 3 line E, 4 line B, 5 line C, and 7 selects nothing.
- R5: A shared line bit `line_x[g]` is the OR of all second-level sources `j` with `j / GRP_W == g` whose selector picks line x, so one line merges at most `GRP_W` sources.
- R6: Code 1 on a second-level source hands it off. The OR of the handed-off sources of group `g` enters the first level as entry `N_LOW+g`. That entry is routed by the selector at address `N_LOW+N_HIGH+g` with the R3 codes, onto bit `N_LOW+g` of the first-level outputs.
- R7: Code 6 on second-level source `j` drives `boot_req[j]` with that source and nothing else. The boot microcontroller cannot be reached through the hand-off path.
- R8: A write with `cfg_we` high loads `cfg_sel` into selector `cfg_idx` at the rising clock edge. The new route is visible right after that edge and not before it. Interrupt inputs reach the outputs in the same cycle.
- R9: A cycle with `cfg_we` low, or with `cfg_idx` at or above `N_LOW+N_HIGH+N_GROUPS`, leaves every selector unchanged.
- R10: Whatever the selector contents, a single active source asserts at most one output bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of all selectors |
| irq_in | input | N_LOW+N_HIGH | Level interrupt sources, first-level indices at the bottom |
| cfg_we | input | 1 | Selector write strobe |
| cfg_idx | input | IDX_W | Selector address: sources, then hand-off group entries |
| cfg_sel | input | 3 | Selector value to write |
| main_req | output | N_LOW+N_GROUPS | Requests to the main processor (sources, then hand-off groups) |
| auxa_req | output | N_LOW+N_GROUPS | Requests to auxiliary processor A |
| auxb_req | output | N_LOW+N_GROUPS | Requests to auxiliary processor B |
| line_a | output | N_GROUPS | Shared line A per group (main processor) |
| line_b | output | N_GROUPS | Shared line B per group (auxiliary A) |
| line_c | output | N_GROUPS | Shared line C per group (auxiliary B) |
| line_d | output | N_GROUPS | Shared line D per group (main processor) |
| line_e | output | N_GROUPS | Shared line E per group (main processor) |
| boot_req | output | N_HIGH | Per-source requests to the boot microcontroller |

## Verification
A corrupted selector misroutes its source, and the fault is visible in the very next cycle in which that source is active. The request appears on the wrong output bit or vanishes, and every output is compared against an independent model after each stimulus. A group mix-up in the second level shows as the wrong `line_x[g]` or hand-off bit as soon as a source of that group fires. A faulty write decode shows one cycle after the write as a changed route on an untouched source. The sweeps drive each source alone under every code, and the hand-off selectors under every code, so a single wrong decode is caught at the first source that uses it.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int SEL_W = 3;
  typedef logic [SEL_W-1:0] dsel_t;

  // first-level codes
  localparam dsel_t L1_MAIN = 3'd0;
  localparam dsel_t L1_AUXA = 3'd1;
  localparam dsel_t L1_AUXB = 3'd2;

  // second-level codes; the numbering is the decode order
  localparam dsel_t L2_LINE_A  = 3'd0;
  localparam dsel_t L2_HANDOFF = 3'd1;
  localparam dsel_t L2_LINE_D  = 3'd2;
  localparam dsel_t L2_LINE_E  = 3'd3;
  localparam dsel_t L2_LINE_B  = 3'd4;
  localparam dsel_t L2_LINE_C  = 3'd5;
  localparam dsel_t L2_BOOT    = 3'd6;

  // codes 0..5 of the second level feed per-group OR trees
  localparam int L2_GROUPED = 6;
endpackage

// File: rtl/irq_sel_regs.sv
module irq_sel_regs
  import irq_route_pkg::*;
#(
  parameter int N_CFG = 18,
  parameter int IDX_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  dsel_t                  cfg_sel,
  output logic [N_CFG*SEL_W-1:0] sel_q
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(N_CFG);

  for (genvar e = 0; e < N_CFG; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        sel_q[e*SEL_W +: SEL_W] <= '0;
      else if (cfg_we && cfg_idx == IDX_W'(e))
        sel_q[e*SEL_W +: SEL_W] <= cfg_sel;
    end

    // R8: an addressed write lands one edge later
    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_idx == IDX_W'(e)) |=> sel_q[e*SEL_W +: SEL_W] == $past(cfg_sel));
  end

  // R9: no strobe, no change
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(sel_q));

  // R9: out-of-range address, no change
  a_r9_range_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && {1'b0, cfg_idx} >= LIMIT) |=> $stable(sel_q));
endmodule

// File: rtl/irq_l1_router.sv
module irq_l1_router
  import irq_route_pkg::*;
#(
  parameter int N_IN = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_IN-1:0]       req_in,
  input  logic [N_IN*SEL_W-1:0] sel,
  output logic [N_IN-1:0]       main_req,
  output logic [N_IN-1:0]       auxa_req,
  output logic [N_IN-1:0]       auxb_req
);
  for (genvar i = 0; i < N_IN; i++) begin : g_src
    dsel_t s;
    assign s = sel[i*SEL_W +: SEL_W];
    assign main_req[i] = req_in[i] && (s == L1_MAIN);
    assign auxa_req[i] = req_in[i] && (s == L1_AUXA);
    assign auxb_req[i] = req_in[i] && (s == L1_AUXB);

    // R3, R10: one entry never lands on two processors
    a_r3_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({main_req[i], auxa_req[i], auxb_req[i]}));
  end
endmodule

// File: rtl/irq_l2_router.sv
module irq_l2_router
  import irq_route_pkg::*;
#(
  parameter int N_HIGH   = 8,
  parameter int GRP_W    = 4,
  parameter int N_GROUPS = 2
) (
  input  logic [N_HIGH-1:0]       irq_hi,
  input  logic [N_HIGH*SEL_W-1:0] sel,
  output logic [N_GROUPS-1:0]     line_a,
  output logic [N_GROUPS-1:0]     line_b,
  output logic [N_GROUPS-1:0]     line_c,
  output logic [N_GROUPS-1:0]     line_d,
  output logic [N_GROUPS-1:0]     line_e,
  output logic [N_GROUPS-1:0]     handoff,
  output logic [N_HIGH-1:0]       boot_req
);
  logic [N_HIGH-1:0]   hit [L2_GROUPED];
  logic [N_GROUPS-1:0] grp [L2_GROUPED];

  for (genvar j = 0; j < N_HIGH; j++) begin : g_src
    dsel_t s;
    assign s = sel[j*SEL_W +: SEL_W];
    for (genvar d = 0; d < L2_GROUPED; d++) begin : g_code
      assign hit[d][j] = irq_hi[j] && (s == dsel_t'(d));
    end
    assign boot_req[j] = irq_hi[j] && (s == L2_BOOT);
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    localparam int LO = g * GRP_W;
    localparam int HI = (((g + 1) * GRP_W < N_HIGH) ? (g + 1) * GRP_W : N_HIGH) - 1;
    for (genvar d = 0; d < L2_GROUPED; d++) begin : g_or
      assign grp[d][g] = |hit[d][HI:LO];
    end
  end

  assign line_a  = grp[int'(L2_LINE_A)];
  assign handoff = grp[int'(L2_HANDOFF)];
  assign line_d  = grp[int'(L2_LINE_D)];
  assign line_e  = grp[int'(L2_LINE_E)];
  assign line_b  = grp[int'(L2_LINE_B)];
  assign line_c  = grp[int'(L2_LINE_C)];
endmodule

// File: rtl/irq_dest_router.sv
module irq_dest_router
  import irq_route_pkg::*;
#(
  parameter int N_LOW    = 128,
  parameter int N_HIGH   = 64,
  parameter int GRP_W    = 32,
  localparam int N_GROUPS = (N_HIGH + GRP_W - 1) / GRP_W,
  localparam int N_SRC    = N_LOW + N_HIGH,
  localparam int N_L1     = N_LOW + N_GROUPS,
  localparam int N_CFG    = N_SRC + N_GROUPS,
  localparam int IDX_W    = $clog2(N_CFG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_SRC-1:0]    irq_in,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [SEL_W-1:0]    cfg_sel,
  output logic [N_L1-1:0]     main_req,
  output logic [N_L1-1:0]     auxa_req,
  output logic [N_L1-1:0]     auxb_req,
  output logic [N_GROUPS-1:0] line_a,
  output logic [N_GROUPS-1:0] line_b,
  output logic [N_GROUPS-1:0] line_c,
  output logic [N_GROUPS-1:0] line_d,
  output logic [N_GROUPS-1:0] line_e,
  output logic [N_HIGH-1:0]   boot_req
);
  logic [N_CFG*SEL_W-1:0] sel_q;
  logic [N_GROUPS-1:0]    handoff;
  logic [N_HIGH-1:0]      irq_hi;
  logic [N_L1-1:0]        l1_in;
  logic [N_L1*SEL_W-1:0]  l1_sel;

  irq_sel_regs #(.N_CFG(N_CFG), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .sel_q(sel_q)
  );

  assign irq_hi = irq_in[N_SRC-1:N_LOW];

  irq_l2_router #(.N_HIGH(N_HIGH), .GRP_W(GRP_W), .N_GROUPS(N_GROUPS)) u_l2 (
    .irq_hi(irq_hi), .sel(sel_q[N_SRC*SEL_W-1:N_LOW*SEL_W]),
    .line_a(line_a), .line_b(line_b), .line_c(line_c), .line_d(line_d),
    .line_e(line_e), .handoff(handoff), .boot_req(boot_req)
  );

  // hand-off groups sit above the direct first-level sources
  assign l1_in  = {handoff, irq_in[N_LOW-1:0]};
  assign l1_sel = {sel_q[N_CFG*SEL_W-1:N_SRC*SEL_W], sel_q[N_LOW*SEL_W-1:0]};

  irq_l1_router #(.N_IN(N_L1)) u_l1 (
    .clk(clk), .rst_n(rst_n), .req_in(l1_in), .sel(l1_sel),
    .main_req(main_req), .auxa_req(auxa_req), .auxb_req(auxb_req)
  );

  for (genvar i = 0; i < N_LOW; i++) begin : g_low_chk
    // R2: a first-level output bit needs its own source
    a_r2_low_origin: assert property (@(posedge clk) disable iff (!rst_n)
      (main_req[i] || auxa_req[i] || auxb_req[i]) |-> irq_in[i]);
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp_chk
    localparam int LO = N_LOW + g * GRP_W;
    localparam int HI = N_LOW + ((((g + 1) * GRP_W < N_HIGH) ? (g + 1) * GRP_W : N_HIGH) - 1);
    // R5: a shared line bit needs an active source of its own group
    a_r5_line_origin: assert property (@(posedge clk) disable iff (!rst_n)
      (line_a[g] || line_b[g] || line_c[g] || line_d[g] || line_e[g]) |-> (|irq_in[HI:LO]));
    // R6: a merged hand-off request with a valid code reaches a processor
    a_r6_handoff_path: assert property (@(posedge clk) disable iff (!rst_n)
      (handoff[g] && sel_q[(N_SRC+g)*SEL_W +: SEL_W] <= L1_AUXB)
        |-> (main_req[N_LOW+g] || auxa_req[N_LOW+g] || auxb_req[N_LOW+g]));
  end
endmodule

// File: tb/irq_dest_router_tb.sv
module irq_dest_router_tb;
  localparam int NL = 8, NH = 8, GW = 4, NG = 2, NS = 16, N1 = 10, NC = 18, IW = 5;

  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [NS-1:0] irq_in = '0;
  logic [IW-1:0] cfg_idx = '0;
  logic [2:0] cfg_sel = '0;
  logic [N1-1:0] main_req, auxa_req, auxb_req;
  logic [NG-1:0] line_a, line_b, line_c, line_d, line_e;
  logic [NH-1:0] boot_req;

  int sel_m [NC];
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  irq_dest_router #(.N_LOW(NL), .N_HIGH(NH), .GRP_W(GW)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .main_req(main_req), .auxa_req(auxa_req), .auxb_req(auxb_req),
    .line_a(line_a), .line_b(line_b), .line_c(line_c), .line_d(line_d), .line_e(line_e),
    .boot_req(boot_req)
  );

  function automatic logic [47:0] model();
    logic [N1-1:0] m = '0, a = '0, b = '0;
    logic [NG-1:0] la = '0, lb = '0, lc = '0, ld = '0, le = '0, ho = '0;
    logic [NH-1:0] bt = '0;
    for (int i = 0; i < NL; i++)
      case (sel_m[i]) 0: m[i] = irq_in[i]; 1: a[i] = irq_in[i]; 2: b[i] = irq_in[i]; default: ; endcase
    for (int j = 0; j < NH; j++) begin
      logic v = irq_in[NL+j];
      int g = j / GW;
      case (sel_m[NL+j])
        0: la[g] |= v; 1: ho[g] |= v; 2: ld[g] |= v; 3: le[g] |= v;
        4: lb[g] |= v; 5: lc[g] |= v; 6: bt[j] = v; default: ;
      endcase
    end
    for (int g = 0; g < NG; g++)
      case (sel_m[NS+g]) 0: m[NL+g] = ho[g]; 1: a[NL+g] = ho[g]; 2: b[NL+g] = ho[g]; default: ; endcase
    return {m, a, b, la, lb, lc, ld, le, bt};
  endfunction

  function automatic logic [47:0] got();
    return {main_req, auxa_req, auxb_req, line_a, line_b, line_c, line_d, line_e, boot_req};
  endfunction

  task automatic check(string tag);
    logic [47:0] e = model();
    logic [47:0] r = got();
    n_chk++;
    if (r !== e) begin
      n_fail++;
      $display("FAIL %s: outputs %h expected %h", tag, r, e);
    end
  endtask

  task automatic wr(int idx, int sel, logic we);
    @(negedge clk);
    cfg_we = we; cfg_idx = IW'(idx); cfg_sel = 3'(sel);
    @(posedge clk); #1;
    cfg_we = 0;
    if (we && idx < NC) sel_m[idx] = sel;
  endtask

  task automatic drive(logic [NS-1:0] v);
    irq_in = v; #1;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < NC; k++) sel_m[k] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset routing, quiet and all active
    drive('0); check("R1");
    drive('1); check("R1");
    if (line_a !== 2'b11 || main_req[NL-1:0] !== 8'hff) begin
      n_chk++; n_fail++;
      $display("FAIL R1: line_a %b main %h expected 11 ff", line_a, main_req);
    end else n_chk++;
    // R3: each first-level source under every code
    for (int s = 0; s < NL; s++)
      for (int c = 0; c < 8; c++) begin
        wr(s, c, 1'b1); drive(NS'(1) << s); check("R3");
      end
    // R2: low sources only, random low codes
    for (int s = 0; s < NL; s++) wr(s, $urandom_range(0, 7), 1'b1);
    drive(16'h00ff); check("R2");
    // R4, R7: each second-level source under every direct code
    for (int j = 0; j < NH; j++)
      for (int c = 0; c < 8; c++) begin
        if (c == 1) continue;
        wr(NL + j, c, 1'b1); drive(NS'(1) << (NL + j));
        check(c == 6 ? "R7" : "R4");
      end
    // R5: group merging on line D
    for (int j = 0; j < NH; j++) wr(NL + j, 2, 1'b1);
    foreach (sel_m[k]) ;
    drive(16'h0100); check("R5");
    drive(16'h0f00); check("R5");
    drive(16'hf000); check("R5");
    drive(16'h0a50); check("R5");
    wr(NL + 5, 4, 1'b1); drive(16'h2000); check("R5");
    // R6: hand-off through both group selectors under every code
    for (int t = 0; t < 2; t++) begin
      int j = (t == 0) ? 2 : 5;
      wr(NL + j, 1, 1'b1);
      for (int c = 0; c < 8; c++) begin
        wr(NS + j / GW, c, 1'b1); drive(NS'(1) << (NL + j)); check("R6");
      end
    end
    // R7: boot never via hand-off (code 6 on group selector)
    wr(NS, 6, 1'b1); drive(16'hff00); check("R7");
    // R8: write timing
    wr(3, 7, 1'b1); drive(16'h0008);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 5'd3; cfg_sel = 3'd1; #1;
    check("R8");
    @(posedge clk); #1;
    cfg_we = 0; sel_m[3] = 1;
    check("R8");
    // R9: strobe low and out-of-range addresses
    wr(3, 2, 1'b0); drive('1); check("R9");
    for (int a = NC; a < 32; a++) wr(a, 3, 1'b1);
    drive('1); check("R9");
    drive(16'h0008); check("R9");
    // R10: random configurations, one active source at a time
    for (int n = 0; n < 300; n++) begin
      logic [47:0] r;
      wr($urandom_range(0, NC - 1), $urandom_range(0, 7), 1'b1);
      drive(NS'(1) << $urandom_range(0, NS - 1));
      check("R10");
      r = got(); n_chk++;
      if ($countones(r) > 1) begin
        n_fail++;
        $display("FAIL R10: %0d output bits set, expected at most 1", $countones(r));
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule